// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A countdown watchdog that a host services over a small byte-addressed register bus. A prescaler divides the input clock into ticks of a fixed period, and the default setting gives 0.6 s at 250 MHz. Each tick lowers a 6-bit count. When the count runs out, the block does not act at once. The first expiry raises a sticky first-timeout flag, which also drives an interrupt-style output, and the count starts again from the programmed initial value. Only a second expiry, with no reload in between, sets the second-timeout flag. That second expiry also issues a one-cycle system reset request, but only while the external reboot-enable input is high.

Software holds the count off by writing the reload key to the reload register. It programs the timeout in ticks through the initial-value register and starts or freezes counting with the halt bit. It learns what happened from a write-one-to-clear status register. The timeout flags sit in a power-on reset domain of their own. The warm reset that the request causes re-initialises the counter, control and initial value, and leaves the flags set, so software can see after the reboot why the reboot occurred.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset, status (offset 4) reads 0, control (offset 8) reads 0x1000 with the halt bit set, the initial-value register (offset 1) reads DEFAULT_INIT (50), the count reads 50, and the reset request and the interrupt output are low.
- R2: While counting, the count drops by exactly one every TICK_CYCLES clocks, counted from the clock edge that clears halt after a reload.
- R3: When a tick finds the count at 1 and no first expiry is pending, status bit 1 and the expiry_irq output rise. The count returns to the initial value at that same edge, which lies init×TICK_CYCLES clocks after the start.
- R4: If no reload arrives after a first expiry, the next expiry, init×TICK_CYCLES clocks later, sets status bit 10.
- R5: On a second expiry with reboot_en high, sys_rst_req is high for exactly one cycle and status bit 9 (boot flag) is set. With reboot_en low, no request is issued and bit 9 stays clear.
- R6: Writing 0x01 to offset 0 loads the count from the initial value, restarts the prescaler and cancels a pending first expiry, so the next expiry counts as a first one again. Any other value written there has no effect.
- R7: Offset 1 holds the timeout in bits 5:0 and two spare bits in 7:6. A write stores bits 7:6 always, but stores bits 5:0 only if they lie in 4..63. A value of 0 to 3 leaves the field unchanged.
- R8: While control bit 12 (halt) is 1, the count and the prescaler phase are frozen. Clearing it resumes from the frozen phase.
- R9: Status bits 1, 9 and 10 are write-one-to-clear. A written 1 clears its bit and a written 0 leaves it unchanged.
- R10: The warm reset input restores the count, halt bit and initial value to their reset values but keeps the status bits. Only the power-on reset clears status.
- R11: A read of offset 0 returns the current count in bits 5:0. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including status |
| warm_rst_n | input | 1 | Asynchronous warm reset, active low; leaves status intact |
| reboot_en | input | 1 | Permits a reset request on second expiry |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| expiry_irq | output | 1 | Level copy of the first-timeout status flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A count, phase or stage that has gone wrong shows up at the ports in the cycle of the expiry edge. The first-timeout flag, the second-timeout flag or the request then appears one clock early or late, or the first and second stages trade places. The bench therefore samples each flag one cycle before and one cycle after the expiry edge it computes. A prescaler phase that a halt or reload fails to freeze or clear moves the next count step by some clocks, and the bench sees this by reading the count just before and just after the tick it expects. If the status reset domain is wrong, the flags vanish on the first warm reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned SPARE_W = 2;

  // Byte offsets on the register bus
  localparam logic [3:0] OFF_RELOAD = 4'h0;
  localparam logic [3:0] OFF_INIT   = 4'h1;
  localparam logic [3:0] OFF_STAT   = 4'h4;
  localparam logic [3:0] OFF_CTRL   = 4'h8;

  // Bit positions
  localparam int unsigned ST_FIRST  = 1;
  localparam int unsigned ST_BOOT   = 9;
  localparam int unsigned ST_SECOND = 10;
  localparam int unsigned CT_HALT   = 12;

  localparam logic [7:0]       RELOAD_KEY = 8'h01;
  localparam logic [CNT_W-1:0] INIT_MIN   = CNT_W'(4);

  localparam logic [REG_W-1:0] STAT_MASK =
    (REG_W'(1) << ST_FIRST) | (REG_W'(1) << ST_BOOT) | (REG_W'(1) << ST_SECOND);

  // Timeout field values below INIT_MIN are refused
  function automatic logic init_legal(input logic [CNT_W-1:0] v);
    return v >= INIT_MIN;
  endfunction

  // A tick that finds the count at one (or lower) is an expiry
  function automatic logic is_last_tick(input logic [CNT_W-1:0] cnt);
    return cnt <= CNT_W'(1);
  endfunction

  // Build the set vector for the sticky status flags
  function automatic logic [REG_W-1:0] status_set(input logic first_ev,
                                                  input logic second_ev,
                                                  input logic boot_ev);
    logic [REG_W-1:0] v;
    v = '0;
    v[ST_FIRST]  = first_ev;
    v[ST_SECOND] = second_ev;
    v[ST_BOOT]   = boot_ev;
    return v;
  endfunction

  // Write-one-to-clear update, setting wins over clearing
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set);
    return ((cur & ~clr) | set) & STAT_MASK;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 150_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] phase_q;

  assign tick = run && !restart && (phase_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEFAULT_INIT = CNT_W'(50)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             exp_first,
  output logic             exp_second
);

  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             expire;

  always_comb begin
    expire     = tick && !reload && is_last_tick(count_q);
    exp_first  = expire && !armed_q;
    exp_second = expire && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= DEFAULT_INIT;
      armed_q <= 1'b0;
    end else if (reload) begin
      count_q <= init_val;
      armed_q <= 1'b0;
    end else if (expire) begin
      count_q <= init_val;
      armed_q <= !armed_q;
    end else if (tick) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  assign count = count_q;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned      ADDR_W       = 4,
  parameter logic [CNT_W-1:0] DEFAULT_INIT = CNT_W'(50)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              exp_first,
  input  logic              exp_second,
  input  logic              reboot_en,
  output logic [REG_W-1:0]  rdata,
  output logic              halt,
  output logic [CNT_W-1:0]  init_field,
  output logic              reload_hit,
  output logic [REG_W-1:0]  status,
  output logic              rst_req
);

  logic               hit_reload, hit_init, hit_stat, hit_ctrl;
  logic [SPARE_W-1:0] spare_q;
  logic [CNT_W-1:0]   init_q;
  logic               halt_q;
  logic [REG_W-1:0]   status_q;
  logic [REG_W-1:0]   stat_clr;
  logic [REG_W-1:0]   stat_set;
  logic               rst_req_q;

  always_comb begin
    hit_reload = (addr == ADDR_W'(OFF_RELOAD));
    hit_init   = (addr == ADDR_W'(OFF_INIT));
    hit_stat   = (addr == ADDR_W'(OFF_STAT));
    hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
    reload_hit = wr && hit_reload && (wdata[7:0] == RELOAD_KEY);
    stat_clr   = (wr && hit_stat) ? (wdata & STAT_MASK) : '0;
    stat_set   = status_set(exp_first, exp_second, exp_second && reboot_en);
  end

  // Initial-value register: spare bits always taken, timeout field only if legal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_q <= '0;
      init_q  <= DEFAULT_INIT;
    end else if (wr && hit_init) begin
      spare_q <= wdata[CNT_W +: SPARE_W];
      if (init_legal(wdata[CNT_W-1:0])) init_q <= wdata[CNT_W-1:0];
    end
  end

  // Control register: halt is set out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                halt_q <= 1'b1;
    else if (wr && hit_ctrl)   halt_q <= wdata[CT_HALT];
  end

  // Status lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) status_q <= '0;
    else        status_q <= w1c_next(status_q, stat_clr, stat_set);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_req_q <= 1'b0;
    else        rst_req_q <= exp_second && reboot_en;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_reload)    rdata = REG_W'(count);
      else if (hit_init) rdata = REG_W'({spare_q, init_q});
      else if (hit_stat) rdata = status_q;
      else if (hit_ctrl) rdata = REG_W'(halt_q) << CT_HALT;
    end
  end

  assign halt       = halt_q;
  assign init_field = init_q;
  assign status     = status_q;
  assign rst_req    = rst_req_q;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned      TICK_CYCLES  = 150_000_000,
  parameter logic [CNT_W-1:0] DEFAULT_INIT = CNT_W'(50),
  parameter int unsigned      ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              reboot_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              expiry_irq,
  output logic              sys_rst_req
);

  logic             rst_n;
  logic             tick;
  logic             halt_q;
  logic             reload_hit;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] init_field;
  logic             exp_first;
  logic             exp_second;
  logic [REG_W-1:0] status_q;

  assign rst_n = por_n & warm_rst_n;

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!halt_q),
    .restart (reload_hit),
    .tick    (tick)
  );

  wdt_countdown #(.DEFAULT_INIT(DEFAULT_INIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .reload     (reload_hit),
    .init_val   (init_field),
    .count      (count_q),
    .exp_first  (exp_first),
    .exp_second (exp_second)
  );

  wdt_regs #(.ADDR_W(ADDR_W), .DEFAULT_INIT(DEFAULT_INIT)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .count      (count_q),
    .exp_first  (exp_first),
    .exp_second (exp_second),
    .reboot_en  (reboot_en),
    .rdata      (bus_rdata),
    .halt       (halt_q),
    .init_field (init_field),
    .reload_hit (reload_hit),
    .status     (status_q),
    .rst_req    (sys_rst_req)
  );

  assign expiry_irq = status_q[ST_FIRST];

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        por_n,
  input logic        warm_rst_n,
  input logic        reboot_en,
  input logic        sys_rst_req,
  input logic        halt,
  input logic        reload_hit,
  input logic [5:0]  count,
  input logic [5:0]  init_val,
  input logic        exp_first,
  input logic        exp_second,
  input logic [31:0] status
);

  // R5
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R5
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    sys_rst_req |-> ($past(reboot_en) && $past(exp_second)));

  // R4
  second_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    exp_second |=> status[10]);

  // R3
  first_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    exp_first |=> (status[1] && count == $past(init_val)));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    (halt && !reload_hit) |=> $stable(count));

  // R7
  init_range_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    init_val >= 6'd4);

endmodule

bind wdt_two_stage wdt_checker u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .warm_rst_n  (warm_rst_n),
  .reboot_en   (reboot_en),
  .sys_rst_req (sys_rst_req),
  .halt        (halt_q),
  .reload_hit  (reload_hit),
  .count       (count_q),
  .init_val    (init_field),
  .exp_first   (exp_first),
  .exp_second  (exp_second),
  .status      (status_q)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;

  localparam int T = 4;  // tick length in clocks for the bench
  localparam int NV = 4;
  // {timeout ticks[6:1], reboot_en[0]}
  localparam logic [6:0] VEC [NV] = '{ {6'd4, 1'b1}, {6'd7, 1'b0}, {6'd5, 1'b0}, {6'd12, 1'b1} };

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        reboot_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        expiry_irq;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.TICK_CYCLES(T), .DEFAULT_INIT(6'd50), .ADDR_W(4)) dut (
    .clk, .por_n, .warm_rst_n, .reboot_en, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_rdata, .expiry_irq, .sys_rst_req
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    por_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(4'h4, d); chk("R1", "status", d, 32'h0);
    rd(4'h8, d); chk("R1", "control", d, 32'h1000);
    rd(4'h1, d); chk("R1", "init", d, 32'd50);
    rd(4'h0, d); chk("R1", "count", d, 32'd50);
    chk("R1", "req", {31'b0, sys_rst_req}, 32'h0);
    chk("R1", "irq", {31'b0, expiry_irq}, 32'h0);
    // R11 unmapped offset
    rd(4'h2, d); chk("R11", "unmapped", d, 32'h0);

    // Table of timeout/enable vectors: two-stage expiry timing
    for (int i = 0; i < NV; i++) begin
      logic [5:0] ini;
      logic       en;
      ini = VEC[i][6:1];
      en  = VEC[i][0];
      reboot_en = en;
      wr(4'h1, {26'b0, ini});
      wr(4'h0, 32'h1);
      wr(4'h4, 32'h602);
      wr(4'h8, 32'h0);
      cyc(int'(ini) * T - 1);
      rd(4'h4, d); chk("R3", "first early", d[1], 32'h0);
      cyc(1);
      rd(4'h4, d); chk("R3", "first flag", d[1], 32'h1);
      chk("R3", "irq", {31'b0, expiry_irq}, 32'h1);
      rd(4'h0, d); chk("R11", "count reloaded", d, {26'b0, ini});
      cyc(int'(ini) * T - 1);
      rd(4'h4, d); chk("R4", "second early", d[10], 32'h0);
      chk("R5", "req early", {31'b0, sys_rst_req}, 32'h0);
      cyc(1);
      rd(4'h4, d); chk("R4", "second flag", d[10], 32'h1);
      chk("R5", "boot flag", d[9], {31'b0, en});
      chk("R5", "req", {31'b0, sys_rst_req}, {31'b0, en});
      cyc(1);
      chk("R5", "req one cycle", {31'b0, sys_rst_req}, 32'h0);
      wr(4'h8, 32'h1000);
    end

    // R9 write-one-to-clear (last vector left bits 1, 9, 10 set)
    rd(4'h4, d); chk("R9", "before", d, 32'h602);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R9", "zero write", d, 32'h602);
    wr(4'h4, 32'h400);
    rd(4'h4, d); chk("R9", "clear bit10", d, 32'h202);
    wr(4'h4, 32'h202);
    rd(4'h4, d); chk("R9", "clear rest", d, 32'h0);

    // R7 initial-value field legality and spare bits
    wr(4'h1, 32'hC2);
    rd(4'h1, d); chk("R7", "illegal 2 ignored", d, 32'hCC);
    wr(4'h1, 32'h43);
    rd(4'h1, d); chk("R7", "illegal 3 ignored", d, 32'h4C);
    wr(4'h1, 32'h45);
    rd(4'h1, d); chk("R7", "legal 5", d, 32'h45);
    wr(4'h1, 32'h08);
    rd(4'h1, d); chk("R7", "legal 8", d, 32'h08);

    // R6 reload key
    wr(4'h0, 32'h2);
    rd(4'h0, d); chk("R6", "non-key ignored", d, 32'd12);
    wr(4'h0, 32'h1);
    rd(4'h0, d); chk("R6", "key reloads", d, 32'd8);

    // R8 halt holds
    cyc(20);
    rd(4'h0, d); chk("R8", "halted count", d, 32'd8);

    // R2 tick rate
    wr(4'h8, 32'h0);
    cyc(T - 1);
    rd(4'h0, d); chk("R2", "before tick", d, 32'd8);
    cyc(1);
    rd(4'h0, d); chk("R2", "first tick", d, 32'd7);
    cyc(T);
    rd(4'h0, d); chk("R2", "second tick", d, 32'd6);

    // R8 halt freezes phase, resume from frozen phase
    wr(4'h8, 32'h1000);
    cyc(3 * T);
    rd(4'h0, d); chk("R8", "frozen", d, 32'd6);
    wr(4'h8, 32'h0);
    cyc(T - 2);
    rd(4'h0, d); chk("R8", "resume early", d, 32'd6);
    cyc(1);
    rd(4'h0, d); chk("R8", "resume tick", d, 32'd5);

    // R6 reload between expiries cancels the pending stage
    reboot_en = 1'b1;
    wr(4'h0, 32'h1);
    cyc(8 * T - 1);
    rd(4'h4, d); chk("R6", "no expiry yet", d, 32'h0);
    cyc(1);
    rd(4'h4, d); chk("R6", "first expiry", d, 32'h2);
    wr(4'h4, 32'h2);
    wr(4'h0, 32'h1);
    cyc(8 * T - 1);
    rd(4'h4, d); chk("R6", "quiet after reload", d, 32'h0);
    cyc(1);
    rd(4'h4, d); chk("R6", "counts as first again", d, 32'h2);
    chk("R6", "no request", {31'b0, sys_rst_req}, 32'h0);

    // R10 warm reset keeps status, restores the rest
    warm_rst_n = 1'b0;
    cyc(1);
    warm_rst_n = 1'b1;
    cyc(1);
    rd(4'h4, d); chk("R10", "status kept", d, 32'h2);
    rd(4'h8, d); chk("R10", "halt restored", d, 32'h1000);
    rd(4'h1, d); chk("R10", "init restored", d, 32'd50);
    rd(4'h0, d); chk("R10", "count restored", d, 32'd50);
    por_n = 1'b0;
    cyc(1);
    por_n = 1'b1;
    cyc(1);
    rd(4'h4, d); chk("R10", "power-on clears status", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule